// File: doc/BRIEF.md
# Bundle Instruction Splitter

This block takes one fixed-size bundle of 16 words of 16 bits each and cuts it into the variable-length instructions it holds. The top word is a per-word end marker mask, and the 15 words below it carry instruction text. Each instruction is one to five words long. The block finds the instruction edges and fills up to 12 output slots in program order. Each slot carries a valid flag, the word offset, the length in words, the instruction text aligned to bit 0, and a branch flag. The branch flag comes from a caller-supplied table indexed by the low opcode byte.

The block also counts the branches in the bundle. It raises a single illegal flag for any bundle that breaks a structural limit. An illegal bundle clears every slot, so nothing from it is passed on as executable.

Bundles enter on a valid/ready stream and leave through one output register on a valid/ready stream. A bundle is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. The branch table is a plain control input and is sampled together with the bundle.

Top module: `bundle_splitter`

## Requirements
- R1: Word i of the bundle is bits 16i+15:16i. Mask bit i (bundle bit 240+i, for i from 0 to 14) set means word i ends an instruction. The first instruction starts at word 0, and each later one starts on the word after the previous end. Slot k describes the k-th instruction: `slot_offset` holds its first word and `slot_len` holds its word count. Valid slots form a contiguous run starting at slot 0.
- R2: The text of slot k holds the instruction's first word in bits 15:0, its next word in bits 31:16, and so on. Bits above the instruction's length are zero, and every field of a slot that is not valid is zero.
- R3: Words after the last set mask bit have no effect on any output. A bundle with no mask bit set gives no valid slot and is not illegal.
- R4: An instruction of 6 or more words makes the bundle illegal. A 5-word instruction is legal.
- R5: A bundle with more than 12 instructions is illegal. Exactly 12 instructions is legal.
- R6: A slot's branch flag is set when the slot is valid and bit b of `branch_map` is set, where b is bits 7:0 of the slot's first word. `branch_count` is the number of flagged slots. More than 4 branches makes the bundle illegal, and exactly 4 is legal.
- R7: Mask bit 15 (bundle bit 255) is reserved. When it is set, the bundle is illegal.
- R8: When `illegal` is high, all slot valid bits, branch flags, offsets, lengths and texts are zero, and `branch_count` is zero.
- R9: A bundle is accepted when `in_valid && in_ready`, and its result appears on the next cycle with `out_valid` high. `in_ready` is low while `out_valid && !out_ready`, and the outputs stay stable during that stall.
- R10: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle present |
| in_ready | output | 1 | Bundle can be taken |
| in_bundle | input | 256 | Bundle: 15 instruction words and the end mask in the top word |
| branch_map | input | 256 | Branch flag per low opcode byte value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| illegal | output | 1 | Bundle broke a structural limit |
| slot_valid | output | 12 | Per-slot valid, slot 0 in bit 0 |
| slot_branch | output | 12 | Per-slot branch flag |
| slot_offset | output | 48 | 4-bit first-word index per slot, slot k at bits 4k+3:4k |
| slot_len | output | 36 | 3-bit length in words per slot, slot k at bits 3k+2:3k |
| slot_text | output | 960 | 80-bit text per slot, slot k at bits 80k+79:80k |
| branch_count | output | 4 | Number of branch slots |

## Verification
The hardest cases to reach are those where one bundle sits right on a limit, such as 12 against 13 instructions, 4 against 5 branches, or 5 against 6 words. Another hard case is a bundle whose branch opcode bytes fall on the second word of an instruction, where they must not count as branches. The stimulus builds every bundle from a numbered word pattern, so each word's low byte is its own index. The branch table is then a 15-bit word mask, and each table vector pairs an end mask with a branch mask aimed at one of these edges. A directed test stalls the output, offers a second bundle during the stall, and then releases the output. This checks that the first result holds and that the second follows directly after it.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
  parameter int WORD_W     = 16;
  parameter int NUM_WORDS  = 16;
  parameter int MAX_LEN    = 5;
  parameter int MAX_SLOTS  = 12;
  parameter int MAX_BR     = 4;
  parameter int OPC_W      = 8;

  localparam int INSN_WORDS = NUM_WORDS - 1;
  localparam int BUNDLE_W   = WORD_W * NUM_WORDS;
  localparam int TEXT_W     = WORD_W * MAX_LEN;
  localparam int OFS_W      = $clog2(NUM_WORDS);
  localparam int LEN_W      = $clog2(MAX_LEN + 1);
  localparam int BRC_W      = $clog2(MAX_SLOTS + 1);
  localparam int MAP_W      = 2 ** OPC_W;
endpackage

// File: rtl/bsplit_bounds.sv
module bsplit_bounds
  import bsplit_pkg::*;
(
  input  logic [NUM_WORDS-1:0] end_mask,
  output logic [MAX_SLOTS-1:0] slot_on,
  output logic [OFS_W-1:0]     slot_ofs [MAX_SLOTS],
  output logic [LEN_W-1:0]     slot_len [MAX_SLOTS],
  output logic                 too_long,
  output logic                 too_many
);
  int cnt;
  int start;
  int run;

  always_comb begin
    cnt      = 0;
    start    = 0;
    run      = 0;
    too_long = 1'b0;
    slot_on  = '0;
    for (int s = 0; s < MAX_SLOTS; s++) begin
      slot_ofs[s] = '0;
      slot_len[s] = '0;
    end
    for (int w = 0; w < INSN_WORDS; w++) begin
      if (end_mask[w]) begin
        run = w - start + 1;
        if (run > MAX_LEN) too_long = 1'b1;
        for (int s = 0; s < MAX_SLOTS; s++) begin
          if (s == cnt) begin
            slot_on[s]  = 1'b1;
            slot_ofs[s] = OFS_W'(start);
            slot_len[s] = LEN_W'(run);
          end
        end
        cnt   = cnt + 1;
        start = w + 1;
      end
    end
    too_many = (cnt > MAX_SLOTS);
  end
endmodule

// File: rtl/bsplit_slot.sv
module bsplit_slot
  import bsplit_pkg::*;
(
  input  logic [BUNDLE_W-1:0] bundle,
  input  logic [MAP_W-1:0]    br_map,
  input  logic                on,
  input  logic [OFS_W-1:0]    ofs,
  input  logic [LEN_W-1:0]    len,
  output logic [TEXT_W-1:0]   text,
  output logic                is_br
);
  logic [BUNDLE_W-1:0] shifted;

  assign shifted = bundle >> (int'(ofs) * WORD_W);

  always_comb begin
    text = '0;
    for (int k = 0; k < MAX_LEN; k++) begin
      if (on && (k < int'(len)))
        text[k*WORD_W +: WORD_W] = shifted[k*WORD_W +: WORD_W];
    end
    is_br = on && br_map[text[OPC_W-1:0]];
  end
endmodule

// File: rtl/bundle_splitter.sv
module bundle_splitter
  import bsplit_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [BUNDLE_W-1:0]           in_bundle,
  input  logic [MAP_W-1:0]              branch_map,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic                          illegal,
  output logic [MAX_SLOTS-1:0]          slot_valid,
  output logic [MAX_SLOTS-1:0]          slot_branch,
  output logic [MAX_SLOTS*OFS_W-1:0]    slot_offset,
  output logic [MAX_SLOTS*LEN_W-1:0]    slot_len,
  output logic [MAX_SLOTS*TEXT_W-1:0]   slot_text,
  output logic [BRC_W-1:0]              branch_count
);
  logic [NUM_WORDS-1:0] end_mask;
  logic [MAX_SLOTS-1:0] on_c, br_c;
  logic [OFS_W-1:0]     ofs_c [MAX_SLOTS];
  logic [LEN_W-1:0]     len_c [MAX_SLOTS];
  logic [TEXT_W-1:0]    txt_c [MAX_SLOTS];
  logic                 too_long, too_many, bad_c;
  logic [BRC_W-1:0]     brc_c;
  logic                 take;

  assign end_mask = in_bundle[BUNDLE_W-1 -: WORD_W];

  bsplit_bounds u_bounds (
    .end_mask (end_mask),
    .slot_on  (on_c),
    .slot_ofs (ofs_c),
    .slot_len (len_c),
    .too_long (too_long),
    .too_many (too_many)
  );

  for (genvar s = 0; s < MAX_SLOTS; s++) begin : g_slot
    bsplit_slot u_slot (
      .bundle (in_bundle),
      .br_map (branch_map),
      .on     (on_c[s]),
      .ofs    (ofs_c[s]),
      .len    (len_c[s]),
      .text   (txt_c[s]),
      .is_br  (br_c[s])
    );
  end

  always_comb begin
    brc_c = '0;
    for (int s = 0; s < MAX_SLOTS; s++) brc_c = brc_c + BRC_W'(br_c[s]);
  end

  assign bad_c = end_mask[NUM_WORDS-1] | too_long | too_many |
                 (int'(brc_c) > MAX_BR);

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      illegal      <= 1'b0;
      slot_valid   <= '0;
      slot_branch  <= '0;
      slot_offset  <= '0;
      slot_len     <= '0;
      slot_text    <= '0;
      branch_count <= '0;
    end else begin
      if (take) begin
        out_valid    <= 1'b1;
        illegal      <= bad_c;
        slot_valid   <= bad_c ? '0 : on_c;
        slot_branch  <= bad_c ? '0 : br_c;
        branch_count <= bad_c ? '0 : brc_c;
        for (int s = 0; s < MAX_SLOTS; s++) begin
          slot_offset[s*OFS_W +: OFS_W]  <= bad_c ? '0 : ofs_c[s];
          slot_len[s*LEN_W +: LEN_W]     <= bad_c ? '0 : len_c[s];
          slot_text[s*TEXT_W +: TEXT_W]  <= bad_c ? '0 : txt_c[s];
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bundle_splitter_chk.sv
module bundle_splitter_chk
  import bsplit_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_ready,
  input logic                        out_valid,
  input logic                        out_ready,
  input logic                        illegal,
  input logic [MAX_SLOTS-1:0]        slot_valid,
  input logic [MAX_SLOTS-1:0]        slot_branch,
  input logic [MAX_SLOTS*TEXT_W-1:0] slot_text,
  input logic [BRC_W-1:0]            branch_count
);
  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(slot_text) &&
    $stable(slot_valid) && $stable(illegal) && $stable(branch_count));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_illegal_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> slot_valid == '0 && branch_count == '0 &&
    slot_text == '0);

  p_br_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(slot_branch) == int'(branch_count));

  p_br_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (slot_branch & ~slot_valid) == '0);

  p_br_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !illegal |-> int'(branch_count) <= MAX_BR);

  p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (slot_valid & (slot_valid + 1'b1)) == '0);
endmodule

bind bundle_splitter bundle_splitter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .illegal      (illegal),
  .slot_valid   (slot_valid),
  .slot_branch  (slot_branch),
  .slot_text    (slot_text),
  .branch_count (branch_count)
);

// File: tb/bundle_splitter_test.sv
`timescale 1ns/1ps
module bundle_splitter_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_bundle = '0;
  logic [255:0] branch_map = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         illegal;
  logic [11:0]  slot_valid, slot_branch;
  logic [47:0]  slot_offset;
  logic [35:0]  slot_len;
  logic [959:0] slot_text;
  logic [3:0]   branch_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bundle_splitter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .branch_map(branch_map), .out_valid(out_valid),
    .out_ready(out_ready), .illegal(illegal), .slot_valid(slot_valid),
    .slot_branch(slot_branch), .slot_offset(slot_offset), .slot_len(slot_len),
    .slot_text(slot_text), .branch_count(branch_count)
  );

  typedef struct packed {
    logic [15:0] stop;
    logic [15:0] brm;
    logic        ill;
    logic [11:0] vmask;
    logic [3:0]  brc;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0001, 16'h0000, 1'b0, 12'h001, 4'd0},
    '{16'h7FFF, 16'h0000, 1'b1, 12'h000, 4'd0},
    '{16'h0FFF, 16'h0000, 1'b0, 12'hFFF, 4'd0},
    '{16'h1FFF, 16'h0000, 1'b1, 12'h000, 4'd0},
    '{16'h0010, 16'h0001, 1'b0, 12'h001, 4'd1},
    '{16'h0020, 16'h0000, 1'b1, 12'h000, 4'd0},
    '{16'h0000, 16'h7FFF, 1'b0, 12'h000, 4'd0},
    '{16'h8001, 16'h0000, 1'b1, 12'h000, 4'd0},
    '{16'h0155, 16'h00AB, 1'b1, 12'h000, 4'd0},
    '{16'h0155, 16'h002B, 1'b0, 12'h01F, 4'd4},
    '{16'h0155, 16'h0154, 1'b0, 12'h01F, 4'd0},
    '{16'h4210, 16'h0421, 1'b0, 12'h007, 4'd3},
    '{16'h0003, 16'h7FFC, 1'b0, 12'h003, 4'd0}
  };

  function automatic logic [255:0] mk(input logic [15:0] stop);
    logic [255:0] b;
    b = '0;
    for (int w = 0; w < 15; w++) b[16*w +: 16] = {4'h9, 4'(w), 8'(w)};
    b[255:240] = stop;
    return b;
  endfunction

  task automatic chk(input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] stop, input logic [15:0] brm);
    @(negedge clk);
    in_bundle  = mk(stop);
    branch_map = {240'b0, brm};
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 out_valid in reset", 128'(out_valid), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid after reset", 128'(out_valid), 128'(0));
    chk("R9 ready when empty", 128'(in_ready), 128'(1));

    // Table: R1 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].stop, VECS[i].brm);
      chk("R9 out_valid after accept", 128'(out_valid), 128'(1));
      chk("R4 R5 R6 R7 illegal", 128'(illegal), 128'(VECS[i].ill));
      chk("R1 R8 slot_valid", 128'(slot_valid), 128'(VECS[i].vmask));
      chk("R6 R8 branch_count", 128'(branch_count), 128'(VECS[i].brc));
    end

    // R2: text alignment and zero padding, lengths 2 and 3
    apply(16'h0012, 16'h0000);
    chk("R1 slot0 offset", 128'(slot_offset[3:0]), 128'(0));
    chk("R1 slot0 len", 128'(slot_len[2:0]), 128'(2));
    chk("R2 slot0 text", 128'(slot_text[79:0]), 128'({48'b0, 16'h9101, 16'h9000}));
    chk("R1 slot1 offset", 128'(slot_offset[7:4]), 128'(2));
    chk("R1 slot1 len", 128'(slot_len[5:3]), 128'(3));
    chk("R2 slot1 text", 128'(slot_text[159:80]),
        128'({32'b0, 16'h9404, 16'h9303, 16'h9202}));
    chk("R2 slot2 empty", 128'(slot_text[239:160]), 128'(0));

    // R2: 5-word instruction fills whole text
    apply(16'h0010, 16'h0000);
    chk("R2 five-word text", 128'(slot_text[79:0]),
        128'({16'h9404, 16'h9303, 16'h9202, 16'h9101, 16'h9000}));
    chk("R1 five-word len", 128'(slot_len[2:0]), 128'(5));

    // R8: illegal bundle clears offsets and lengths
    apply(16'h0020, 16'h0001);
    chk("R8 offsets zero", 128'(slot_offset), 128'(0));
    chk("R8 lengths zero", 128'(slot_len), 128'(0));
    chk("R8 branch flags zero", 128'(slot_branch), 128'(0));

    // R6: branch flag lands on slot whose first word matches
    apply(16'h4210, 16'h0020);
    chk("R6 branch flag slot1 only", 128'(slot_branch), 128'(12'h002));

    // R9: stall holds result and blocks input
    @(negedge clk);
    out_ready  = 1'b0;
    in_bundle  = mk(16'h0012);
    branch_map = '0;
    in_valid   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_bundle = mk(16'h0001);
    chk("R9 ready low during stall", 128'(in_ready), 128'(0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 held valid", 128'(out_valid), 128'(1));
    chk("R9 held slot_valid", 128'(slot_valid), 128'(12'h003));
    chk("R9 held len", 128'(slot_len[5:3]), 128'(3));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 second bundle follows", 128'(slot_valid), 128'(12'h001));
    chk("R9 second len", 128'(slot_len[2:0]), 128'(1));
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", 128'(out_valid), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule